// File: doc/BRIEF.md
# Fetch Address Register with Latched Upper Bits

This block holds the 13-bit fetch address of a small accumulator-style processor core. Every clock is one instruction cycle. When nothing else asks for the address, it moves forward by one and wraps from the top of the address space back to zero. Decode logic outside the block raises one-cycle strobes to redirect it. The redirect sources are:

- an interrupt vector,
- a return address popped from the call stack,
- a jump or call target taken from the instruction word,
- a software write to the low address byte, with the data coming from the ALU.

The upper address bits never come from the instruction or from the ALU. They come from a separate 5-bit holding register that software writes ahead of time. A low-byte write copies all five of its bits into the high part. A jump or call copies only its top two bits, because the instruction itself supplies eleven address bits. The ALU only touches the low byte, so a computed jump into a table does not carry into the high part. Such a table wraps inside its current 256-word block unless software updated the holding register first.

The low byte and the holding register can be read back on ports. The high part of the address cannot be read or written directly.

Top module: `fetch_addr_unit`

## Requirements
- R1: When `rst_n` is sampled low at a clock edge, the address becomes 13'h0000 and the holding register becomes 5'h00 after that edge, whatever the other strobes are.
- R2: With no load strobe active, the address becomes the old address plus one after each edge, and 13'h1FFF is followed by 13'h0000.
- R3: On a low-byte write (`low_we`), the new address is {holding[4:0], `alu_res`[7:0]}. The high part of the old address plays no part, so a computed table offset never carries across a 256-word block.
- R4: On a jump or call (`jmp_ld`), the new address is {holding[4:3], `insn_addr`[10:0]}.
- R5: On a return (`ret_ld`), all 13 address bits take `ret_addr`.
- R6: On an interrupt (`vec_ld`), the address becomes 13'h0004.
- R7: When several strobes are active in the same cycle, exactly one source wins, in this order: reset, then interrupt, then return, then jump or call, then low-byte write, then increment.
- R8: The holding register changes only through `latch_we`. Return, interrupt, jump and low-byte loads leave it unchanged. A load in the same cycle as a holding-register write uses the value held before that write.
- R9: `pc_lo_o` always equals bits 7:0 of `pc_o`, and `latch_o` always shows the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per instruction cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| latch_we | input | 1 | Write strobe for the upper-bit holding register |
| latch_wdata | input | 5 | New holding register value |
| low_we | input | 1 | Instruction writes the low address byte |
| alu_res | input | 8 | ALU result for a low-byte write |
| jmp_ld | input | 1 | Jump or call strobe |
| insn_addr | input | 11 | Target address field of the instruction |
| ret_ld | input | 1 | Return strobe, load the popped address |
| ret_addr | input | 13 | Address popped from the return stack |
| vec_ld | input | 1 | Interrupt strobe, load the vector |
| pc_o | output | 13 | Current fetch address |
| pc_lo_o | output | 8 | Readable low byte of the address |
| latch_o | output | 5 | Readback of the holding register |

## Verification
The bench builds a jump target whose top two bits differ from the high part of the current address. A design that took those bits from the instruction or from the old address instead of the holding register would land in the wrong 2K page. A low-byte write made just below a 256-word boundary checks for a carry into the high part. A design that added the offset across the full 13 bits would jump out of the table's block instead of wrapping inside it.

The strobes are stacked in several combinations to check the order in R7. A holding-register write in the same cycle as a jump checks R8: a design that forwarded the new value would fetch from the wrong page. The bench also walks the address through 13'h1FFF to catch a design that stalls there or fails to wrap to zero. It reads the holding register back after returns and interrupts to catch a design that disturbs it on those loads.

// File: rtl/fau_pkg.sv
// Shared types for the fetch address unit.
// Assumes: the enum order carries no meaning; the priority lives in fau_src_pick.
package fau_pkg;
    typedef enum logic [2:0] {
        SRC_RST,
        SRC_VEC,
        SRC_RET,
        SRC_JMP,
        SRC_LOW,
        SRC_INC
    } fau_src_e;
endpackage

// File: rtl/fau_src_pick.sv
// Chooses the single source of the next fetch address from the strobes.
// Assumes: the strobes are decoded one cycle ahead and may overlap;
// overlaps resolve as reset > vector > return > jump > low write > increment.
module fau_src_pick
    import fau_pkg::*;
(
    input  logic     rst_n,
    input  logic     vec_req,
    input  logic     ret_req,
    input  logic     jmp_req,
    input  logic     low_req,
    output fau_src_e src
);
    // Fixed-priority selection of the address source.
    always_comb begin
        if (!rst_n)       src = SRC_RST;
        else if (vec_req) src = SRC_VEC;
        else if (ret_req) src = SRC_RET;
        else if (jmp_req) src = SRC_JMP;
        else if (low_req) src = SRC_LOW;
        else              src = SRC_INC;
    end
endmodule

// File: rtl/fau_upper_latch.sv
// Holding register for the upper address bits, written by software only.
// Assumes: the stack and the load strobes never reach this register; a load in
// the same cycle as a write sees the old contents (plain register, no bypass).
module fau_upper_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Synchronous clear, otherwise load on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !we) |=> $stable(q)); // R8
endmodule

// File: rtl/fau_next_addr.sv
// Forms the next fetch address for the chosen source.
// Assumes: the low-byte path replaces only the low byte and the high part
// from the holding register, so no carry crosses from low to high.
module fau_next_addr
    import fau_pkg::*;
#(
    parameter int                ADDR_W = 13,
    parameter int                LO_W   = 8,
    parameter int                JMP_W  = 11,
    parameter logic [ADDR_W-1:0] VEC    = 13'h004
) (
    input  fau_src_e                src,
    input  logic [ADDR_W-1:0]       pc_q,
    input  logic [ADDR_W-LO_W-1:0]  latch_q,
    input  logic [LO_W-1:0]         alu_res,
    input  logic [JMP_W-1:0]        insn_addr,
    input  logic [ADDR_W-1:0]       ret_addr,
    output logic [ADDR_W-1:0]       pc_d
);
    localparam int HI_W  = ADDR_W - LO_W;
    localparam int JHI_W = ADDR_W - JMP_W;
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] jmp_tgt;
    logic [ADDR_W-1:0] low_tgt;

    // Jump target: the page bits come from the top of the holding register.
    generate
        if (JHI_W > 0) begin : g_jmp_paged
            assign jmp_tgt = {latch_q[HI_W-1 -: JHI_W], insn_addr};
        end else begin : g_jmp_full
            assign jmp_tgt = insn_addr[ADDR_W-1:0];
        end
    endgenerate

    // Low-byte write target: whole holding register above the ALU byte.
    assign low_tgt = {latch_q, alu_res};

    // Source multiplexer for the next address.
    always_comb begin
        unique case (src)
            SRC_RST: pc_d = '0;
            SRC_VEC: pc_d = VEC;
            SRC_RET: pc_d = ret_addr;
            SRC_JMP: pc_d = jmp_tgt;
            SRC_LOW: pc_d = low_tgt;
            default: pc_d = pc_q + ONE;
        endcase
    end
endmodule

// File: rtl/fetch_addr_unit.sv
// Fetch address register of the core with a software-loaded upper-bit latch.
// Assumes: one clock per instruction cycle; strobes are single-cycle pulses
// from decode; the return stack lives outside and only supplies ret_addr.
module fetch_addr_unit
    import fau_pkg::*;
#(
    parameter int                ADDR_W = 13,
    parameter int                LO_W   = 8,
    parameter int                JMP_W  = 11,
    parameter logic [ADDR_W-1:0] VEC    = 13'h004
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    latch_we,
    input  logic [ADDR_W-LO_W-1:0]  latch_wdata,
    input  logic                    low_we,
    input  logic [LO_W-1:0]         alu_res,
    input  logic                    jmp_ld,
    input  logic [JMP_W-1:0]        insn_addr,
    input  logic                    ret_ld,
    input  logic [ADDR_W-1:0]       ret_addr,
    input  logic                    vec_ld,
    output logic [ADDR_W-1:0]       pc_o,
    output logic [LO_W-1:0]         pc_lo_o,
    output logic [ADDR_W-LO_W-1:0]  latch_o
);
    localparam int HI_W  = ADDR_W - LO_W;
    localparam int JHI_W = ADDR_W - JMP_W;

    fau_src_e          src;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;
    logic [HI_W-1:0]   latch_q;

    fau_src_pick u_pick (
        .rst_n   (rst_n),
        .vec_req (vec_ld),
        .ret_req (ret_ld),
        .jmp_req (jmp_ld),
        .low_req (low_we),
        .src     (src)
    );

    fau_upper_latch #(.W(HI_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (latch_we),
        .wdata (latch_wdata),
        .q     (latch_q)
    );

    fau_next_addr #(
        .ADDR_W (ADDR_W),
        .LO_W   (LO_W),
        .JMP_W  (JMP_W),
        .VEC    (VEC)
    ) u_next (
        .src       (src),
        .pc_q      (pc_q),
        .latch_q   (latch_q),
        .alu_res   (alu_res),
        .insn_addr (insn_addr),
        .ret_addr  (ret_addr),
        .pc_d      (pc_d)
    );

    // Address register; reset is folded into the source select.
    always_ff @(posedge clk) begin
        pc_q <= pc_d;
    end

    assign pc_o    = pc_q;
    assign pc_lo_o = pc_q[LO_W-1:0];
    assign latch_o = latch_q;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && latch_o == '0)); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !vec_ld && !ret_ld && !jmp_ld && !low_we)
        |=> pc_o == $past(pc_o) + 1'b1); // R2
    AST_VEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && vec_ld) |=> pc_o == VEC); // R6
    AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ret_ld && !vec_ld) |=> pc_o == $past(ret_addr)); // R5
    AST_JMP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && jmp_ld && !ret_ld && !vec_ld)
        |=> (pc_o[JMP_W-1:0] == $past(insn_addr)
             && pc_o[ADDR_W-1 -: JHI_W] == $past(latch_o[HI_W-1 -: JHI_W]))); // R4
    AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && low_we && !jmp_ld && !ret_ld && !vec_ld)
        |=> (pc_o == {$past(latch_o), $past(alu_res)})); // R3
endmodule

// File: tb/fetch_addr_unit_bench.sv
// Scoreboard bench: the driver models the expected state and queues it; the
// monitor compares the ports one nanosecond after each rising edge.
module fetch_addr_unit_bench;
    typedef struct {
        logic [12:0] pc;
        logic [4:0]  lat;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        latch_we = 1'b0;
    logic [4:0]  latch_wdata = '0;
    logic        low_we = 1'b0;
    logic [7:0]  alu_res = '0;
    logic        jmp_ld = 1'b0;
    logic [10:0] insn_addr = '0;
    logic        ret_ld = 1'b0;
    logic [12:0] ret_addr = '0;
    logic        vec_ld = 1'b0;
    logic [12:0] pc_o;
    logic [7:0]  pc_lo_o;
    logic [4:0]  latch_o;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    logic [12:0] m_pc = '0;
    logic [4:0]  m_lat = '0;

    always #2 clk = ~clk;

    fetch_addr_unit u_fetch_addr_unit (
        .clk(clk), .rst_n(rst_n), .latch_we(latch_we), .latch_wdata(latch_wdata),
        .low_we(low_we), .alu_res(alu_res), .jmp_ld(jmp_ld), .insn_addr(insn_addr),
        .ret_ld(ret_ld), .ret_addr(ret_addr), .vec_ld(vec_ld),
        .pc_o(pc_o), .pc_lo_o(pc_lo_o), .latch_o(latch_o)
    );

    // Driver: apply one cycle of stimulus and queue the expected state.
    task automatic drive(input logic rst, input logic vec, input logic ret,
                         input logic [12:0] ra, input logic jmp, input logic [10:0] ia,
                         input logic low, input logic [7:0] alu,
                         input logic lwe, input logic [4:0] lwd, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = ~rst; vec_ld = vec; ret_ld = ret; ret_addr = ra;
        jmp_ld = jmp; insn_addr = ia; low_we = low; alu_res = alu;
        latch_we = lwe; latch_wdata = lwd;
        if (rst)      m_pc = 13'h0000;
        else if (vec) m_pc = 13'h0004;
        else if (ret) m_pc = ra;
        else if (jmp) m_pc = {m_lat[4:3], ia};
        else if (low) m_pc = {m_lat, alu};
        else          m_pc = m_pc + 13'd1;
        if (rst)      m_lat = 5'h00;
        else if (lwe) m_lat = lwd;
        e.pc = m_pc; e.lat = m_lat; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(0, 0, 0, 13'h0, 0, 11'h0, 0, 8'h0, 0, 5'h0, tag);
    endtask

    // Monitor: pop one expected item per edge and compare all outputs.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (pc_o !== e.pc) begin
                errors++;
                $display("FAIL %s pc_o actual %h expected %h", e.tag, pc_o, e.pc);
            end
            if (pc_lo_o !== e.pc[7:0]) begin
                errors++;
                $display("FAIL R9 pc_lo_o actual %h expected %h", pc_lo_o, e.pc[7:0]);
            end
            if (latch_o !== e.lat) begin
                errors++;
                $display("FAIL %s/R8 latch_o actual %h expected %h", e.tag, latch_o, e.lat);
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset with all strobes active
        drive(1, 1, 1, 13'h1234, 1, 11'h7FF, 1, 8'hFF, 1, 5'h1F, "R1");
        drive(1, 0, 0, 13'h0, 0, 11'h0, 0, 8'h0, 0, 5'h0, "R1");
        // R2: plain increments
        for (int i = 0; i < 4; i++) idle("R2");
        // R8: latch write alone, address keeps stepping
        drive(0, 0, 0, 13'h0, 0, 11'h0, 0, 8'h0, 1, 5'h1A, "R8");
        // R3: low-byte write takes full latch
        drive(0, 0, 0, 13'h0, 0, 11'h0, 1, 8'h34, 0, 5'h0, "R3");
        // R4: jump takes latch[4:3] as page bits
        drive(0, 0, 0, 13'h0, 1, 11'h5A5, 0, 8'h0, 0, 5'h0, "R4");
        // R4: jump with latch page 01 from a different page
        drive(0, 0, 0, 13'h0, 0, 11'h0, 0, 8'h0, 1, 5'h0B, "R8");
        drive(0, 0, 0, 13'h0, 1, 11'h023, 0, 8'h0, 0, 5'h0, "R4");
        // R5: return loads all bits, latch untouched
        drive(0, 0, 1, 13'h0ABC, 0, 11'h0, 0, 8'h0, 0, 5'h0, "R5");
        idle("R2");
        // R6: interrupt vector, latch untouched
        drive(0, 1, 0, 13'h0, 0, 11'h0, 0, 8'h0, 0, 5'h0, "R6");
        idle("R2");
        // R7: interrupt beats return, jump and low write
        drive(0, 1, 1, 13'h1111, 1, 11'h222, 1, 8'h33, 0, 5'h0, "R7");
        // R7: return beats jump and low write
        drive(0, 0, 1, 13'h1555, 1, 11'h222, 1, 8'h33, 0, 5'h0, "R7");
        // R7: jump beats low write
        drive(0, 0, 0, 13'h0, 1, 11'h2AA, 1, 8'h33, 0, 5'h0, "R7");
        // R2: wrap from the top of the space
        drive(0, 0, 1, 13'h1FFE, 0, 11'h0, 0, 8'h0, 0, 5'h0, "R5");
        idle("R2");
        idle("R2");
        idle("R2");
        // R3: computed jump near block end, latch 0, no carry into high part
        drive(0, 0, 0, 13'h0, 0, 11'h0, 0, 8'h0, 1, 5'h00, "R8");
        drive(0, 0, 1, 13'h03FD, 0, 11'h0, 0, 8'h0, 0, 5'h0, "R5");
        drive(0, 0, 0, 13'h0, 0, 11'h0, 1, 8'h02, 0, 5'h0, "R3");
        // R8: same-cycle latch write and jump use the old latch value
        drive(0, 0, 0, 13'h0, 0, 11'h0, 0, 8'h0, 1, 5'h08, "R8");
        drive(0, 0, 0, 13'h0, 1, 11'h100, 0, 8'h0, 1, 5'h10, "R8");
        drive(0, 0, 0, 13'h0, 0, 11'h0, 1, 8'h77, 1, 5'h03, "R8");
        idle("R2");
        // R1: reset mid-run clears address and latch
        drive(1, 0, 1, 13'h0FFF, 0, 11'h0, 0, 8'h0, 0, 5'h0, "R1");
        idle("R2");
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule